// File: doc/BRIEF.md
# Bitmap-to-Printhead Graphics Dump Engine

This engine copies a one-bit-per-dot graphics bitmap, held in a local word-wide cache memory, onto a thermal printhead, one dot row at a time and with no scaling. Each bit in memory is one screen dot, and each printhead element is one dot column. With the default settings the image is 560 dots wide and 455 rows high, and the words are 16 bits wide. Each row is therefore 35 consecutive words, and row r begins at word 35·r of the 16-kiloword store. The dump can run whatever the display is currently showing.

Software pulses `start` with a burn length on `strobe_len`. The engine then raises `busy`. It fetches words through a valid/ready request channel and receives each word on a response channel. The request side follows the usual back-pressure rules: `rd_valid` and `rd_addr` are held until a cycle with `rd_ready` high. Only one request is ever outstanding. A response may come back any number of cycles after its request is accepted, and the engine always takes it at once. One word is prefetched while the current word is being shifted out.

Each dot goes out on `ph_data` with a two-cycle shift clock. After a full row, the engine pulses the latch, holds the burn strobe, and then pulses the paper advance before it starts the next row. After the last row it pulses `done`.

Top module: `gfx_dump_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid`, `ph_clk`, `ph_latch`, `ph_burn` and `paper_adv` are all low.
- R2: A `start` pulse while idle makes `busy` high on the next cycle. A `start` while `busy` is high is ignored: the dump does not restart, and its addresses and row count carry on unchanged.
- R3: One dump issues read addresses 0, 1, 2, … up to ROWS·(ROW_DOTS/WORD_W)−1, each exactly once and in increasing order. Row r therefore starts at word r·ROW_DOTS/WORD_W.
- R4: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` stays unchanged. No new request is raised between an accepted request and its response.
- R5: Each row emits exactly ROW_DOTS shift clocks. Dot c of row r is bit (WORD_W−1 − c mod WORD_W) of word r·ROW_DOTS/WORD_W + c/WORD_W. In other words, each word goes out MSB first, and the MSB is the leftmost dot.
- R6: `ph_clk` is high for exactly one cycle at a time. `ph_data` carries the same value in the low cycle before that high cycle and in the high cycle itself.
- R7: After the last shift clock of a row, `ph_latch` is high for exactly one cycle. `ph_clk` stays low whenever `ph_latch`, `ph_burn` or `paper_adv` is high.
- R8: `ph_burn` rises in the cycle right after the latch pulse and stays high for `strobe_len`+1 cycles. The `strobe_len` value used is the one sampled at the accepted `start`.
- R9: `paper_adv` is high for one cycle, in the cycle right after `ph_burn` falls. There is one such pulse per row.
- R10: After the advance pulse of row ROWS−1, `done` is high for exactly one cycle, in the next cycle. In that same cycle `busy` is low, and exactly ROWS rows have been printed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a dump (acted on only when idle) |
| strobe_len | input | STB_W | Burn length minus one, sampled at start |
| busy | output | 1 | Dump in progress |
| done | output | 1 | One-cycle pulse at the end of a dump |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts the request |
| rd_addr | output | ADDR_W | Word address of the request |
| rsp_valid | input | 1 | Read data valid (always accepted) |
| rsp_data | input | WORD_W | Read data word |
| ph_data | output | 1 | Serial dot data to the printhead |
| ph_clk | output | 1 | Printhead shift clock |
| ph_latch | output | 1 | Transfers the shifted row into the printhead latches |
| ph_burn | output | 1 | Burn strobe |
| paper_adv | output | 1 | One-cycle paper-advance pulse per row |

## Verification
Fetching and shifting overlap. The response for the prefetched word can arrive in the very cycle the shifter sends the last dot of the current word, and the shifter must then load the new word on the next cycle without losing or repeating a dot. The bench sweeps the read latency from zero cycles up past one full word time, under three `rd_ready` stall patterns. This moves the response across every cycle offset of the word being shifted, including that exact coincidence. Every captured dot is compared with the value the bench computes from its own memory contents, and the address sequence and back-pressure rules are checked on each cycle.

// File: rtl/gfx_dump_pkg.sv
package gfx_dump_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_LATCH,
    ST_BURN,
    ST_ADV
  } dump_st_e;
endpackage

// File: rtl/dump_fetch.sv
module dump_fetch #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 14,
  parameter int WPR    = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dump_go,
  input  logic              row_go,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              buf_full,
  output logic [WORD_W-1:0] buf_data,
  input  logic              buf_take
);
  localparam int WL_W = $clog2(WPR + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [WL_W-1:0]   words_left_q;
  logic              pending_q;
  logic              full_q;
  logic [WORD_W-1:0] buf_q;

  assign rd_valid = (words_left_q != '0) && !full_q && !pending_q;
  assign rd_addr  = addr_q;
  assign buf_full = full_q;
  assign buf_data = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q       <= '0;
      words_left_q <= '0;
      pending_q    <= 1'b0;
      full_q       <= 1'b0;
      buf_q        <= '0;
    end else begin
      if (dump_go) addr_q <= '0;
      else if (rd_valid && rd_ready) addr_q <= addr_q + 1'b1;

      if (row_go) words_left_q <= WL_W'(WPR);
      else if (rd_valid && rd_ready) words_left_q <= words_left_q - 1'b1;

      if (rd_valid && rd_ready) pending_q <= 1'b1;
      else if (rsp_valid) pending_q <= 1'b0;

      if (rsp_valid) begin
        full_q <= 1'b1;
        buf_q  <= rsp_data;
      end else if (buf_take) begin
        full_q <= 1'b0;
      end
    end
  end

  p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  p_rsp_expected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> pending_q && !full_q);
endmodule

// File: rtl/dump_shift.sv
module dump_shift #(
  parameter int WORD_W   = 16,
  parameter int ROW_DOTS = 560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_go,
  input  logic              buf_full,
  input  logic [WORD_W-1:0] buf_data,
  output logic              buf_take,
  output logic              ph_data,
  output logic              ph_clk,
  output logic              row_empty
);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam int DOT_W = $clog2(ROW_DOTS + 1);

  logic [WORD_W-1:0] sreg_q;
  logic [BIT_W-1:0]  bits_q;
  logic [DOT_W-1:0]  dots_q;
  logic              phase_q;

  assign buf_take  = (bits_q == '0) && buf_full && (dots_q != '0);
  assign ph_data   = sreg_q[WORD_W-1];
  assign ph_clk    = phase_q;
  assign row_empty = (dots_q == '0) && (bits_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      bits_q  <= '0;
      dots_q  <= '0;
      phase_q <= 1'b0;
    end else if (row_go) begin
      bits_q  <= '0;
      dots_q  <= DOT_W'(ROW_DOTS);
      phase_q <= 1'b0;
    end else if (buf_take) begin
      sreg_q  <= buf_data;
      bits_q  <= BIT_W'(WORD_W);
      phase_q <= 1'b0;
    end else if (bits_q != '0) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        sreg_q  <= {sreg_q[WORD_W-2:0], 1'b0};
        bits_q  <= bits_q - 1'b1;
        dots_q  <= dots_q - 1'b1;
      end
    end
  end

  p_clk_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ph_clk |=> !ph_clk);
  p_data_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_clk) |-> $stable(ph_data));
  p_row_idle_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    row_go |-> bits_q == '0);
endmodule

// File: rtl/dump_seq.sv
module dump_seq
  import gfx_dump_pkg::*;
#(
  parameter int ROWS  = 455,
  parameter int STB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [STB_W-1:0] strobe_len,
  input  logic             row_empty,
  output logic             dump_go,
  output logic             row_go,
  output logic             busy,
  output logic             done,
  output logic             ph_latch,
  output logic             ph_burn,
  output logic             paper_adv
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  dump_st_e         st_q;
  logic [ROW_W-1:0] row_q;
  logic [STB_W-1:0] stb_q;
  logic [STB_W-1:0] cnt_q;
  logic             done_q;
  logic             last_row;

  assign last_row  = (row_q == ROW_W'(ROWS - 1));
  assign dump_go   = (st_q == ST_IDLE) && start;
  assign row_go    = dump_go || ((st_q == ST_ADV) && !last_row);
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign ph_latch  = (st_q == ST_LATCH);
  assign ph_burn   = (st_q == ST_BURN);
  assign paper_adv = (st_q == ST_ADV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      row_q  <= '0;
      stb_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          stb_q <= strobe_len;
          row_q <= '0;
          st_q  <= ST_SHIFT;
        end
        ST_SHIFT: if (row_empty) st_q <= ST_LATCH;
        ST_LATCH: begin
          cnt_q <= stb_q;
          st_q  <= ST_BURN;
        end
        ST_BURN: begin
          if (cnt_q == '0) st_q <= ST_ADV;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_ADV: begin
          if (last_row) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
            st_q  <= ST_SHIFT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);
  p_burn_follows_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ph_latch |=> ph_burn);
  p_adv_follows_burn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_burn) |-> paper_adv);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);
  p_strobe_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(stb_q));
endmodule

// File: rtl/gfx_dump_engine.sv
module gfx_dump_engine #(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 14,
  parameter int ROW_DOTS = 560,
  parameter int ROWS     = 455,
  parameter int STB_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STB_W-1:0]  strobe_len,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              ph_data,
  output logic              ph_clk,
  output logic              ph_latch,
  output logic              ph_burn,
  output logic              paper_adv
);
  localparam int WPR = ROW_DOTS / WORD_W;

  logic              dump_go;
  logic              row_go;
  logic              row_empty;
  logic              buf_full;
  logic              buf_take;
  logic [WORD_W-1:0] buf_data;

  dump_seq #(.ROWS(ROWS), .STB_W(STB_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .strobe_len(strobe_len),
    .row_empty(row_empty), .dump_go(dump_go), .row_go(row_go),
    .busy(busy), .done(done), .ph_latch(ph_latch), .ph_burn(ph_burn),
    .paper_adv(paper_adv)
  );

  dump_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .WPR(WPR)) fetch_i (
    .clk(clk), .rst_n(rst_n), .dump_go(dump_go), .row_go(row_go),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .buf_full(buf_full), .buf_data(buf_data), .buf_take(buf_take)
  );

  dump_shift #(.WORD_W(WORD_W), .ROW_DOTS(ROW_DOTS)) shift_i (
    .clk(clk), .rst_n(rst_n), .row_go(row_go), .buf_full(buf_full),
    .buf_data(buf_data), .buf_take(buf_take), .ph_data(ph_data),
    .ph_clk(ph_clk), .row_empty(row_empty)
  );

  p_quiet_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_latch || ph_burn || paper_adv) |-> !ph_clk);
  p_latch_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ph_latch |=> !ph_latch);
  p_no_read_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid);
endmodule

// File: tb/gfx_dump_engine_tb_top.sv
`timescale 1ns/1ps
module gfx_dump_engine_tb_top;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 14;
  localparam int DOTS   = 32;
  localparam int ROWS   = 3;
  localparam int STB_W  = 4;
  localparam int WPR    = DOTS / WORD_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [STB_W-1:0]  strobe_len = '0;
  logic              busy, done, rd_valid, ph_data, ph_clk, ph_latch, ph_burn, paper_adv;
  logic              rd_ready = 1'b0;
  logic [ADDR_W-1:0] rd_addr;
  logic              rsp_valid = 1'b0;
  logic [WORD_W-1:0] rsp_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  int run_k = 0;
  int lat = 0;
  int stall_mode = 0;
  int exp_addr = 0;
  int row_idx = 0;
  int bit_idx = 0;
  bit done_seen = 1'b0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  gfx_dump_engine #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .ROW_DOTS(DOTS),
                    .ROWS(ROWS), .STB_W(STB_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .strobe_len(strobe_len),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ph_data(ph_data), .ph_clk(ph_clk), .ph_latch(ph_latch),
    .ph_burn(ph_burn), .paper_adv(paper_adv)
  );

  function automatic logic [WORD_W-1:0] mem_word(int a);
    return WORD_W'((a * 40503) ^ (a << 7) ^ 23100);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
    end
  end

  // Memory model: request channel with stalls, response after lat+1 cycles
  initial begin
    int rsp_cnt = 0;
    int rsp_addr = 0;
    bit prev_valid = 1'b0;
    bit prev_ready = 1'b0;
    int prev_addr = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        rsp_valid = 1'b0;
        if (rsp_cnt > 0) begin
          rsp_cnt--;
          if (rsp_cnt == 0) begin
            rsp_valid = 1'b1;
            rsp_data  = mem_word(rsp_addr);
          end
        end
        if (prev_valid && !prev_ready)
          chk(rd_valid && (int'(rd_addr) == prev_addr), "R4 hold", int'(rd_addr), prev_addr);
        if (rd_valid)
          chk(rsp_cnt == 0 && !rsp_valid, "R4 outstanding", rsp_cnt, 0);
        case (stall_mode)
          0: rd_ready = 1'b1;
          1: rd_ready = (cyc % 2) == 0;
          default: rd_ready = (cyc % 3) == 0;
        endcase
        if (rd_valid && rd_ready) begin
          chk(int'(rd_addr) == exp_addr, "R3 address", int'(rd_addr), exp_addr);
          exp_addr++;
          rsp_addr = int'(rd_addr);
          rsp_cnt  = lat + 1;
        end
        prev_valid = rd_valid;
        prev_ready = rd_ready;
        prev_addr  = int'(rd_addr);
      end
    end
  end

  // Printhead monitor
  initial begin
    bit p_clk = 1'b0, p_data = 1'b0, p_latch = 1'b0, p_burn = 1'b0, p_adv = 1'b0, p_done = 1'b0;
    int burn_cnt = 0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (ph_clk) begin
          chk(!p_clk, "R6 single high", 1, 0);
          if (!p_clk) begin
            logic [WORD_W-1:0] w;
            bit e;
            chk(ph_data == p_data, "R6 data setup", ph_data, p_data);
            w = mem_word(row_idx * WPR + bit_idx / WORD_W);
            e = w[WORD_W - 1 - (bit_idx % WORD_W)];
            chk(bit_idx < DOTS, "R5 dot count", bit_idx, DOTS - 1);
            chk(ph_data == e, "R5 dot value", ph_data, e);
            bit_idx++;
          end
        end
        if (ph_latch || ph_burn || paper_adv)
          chk(!ph_clk, "R7 quiet clock", ph_clk, 0);
        if (ph_latch) begin
          chk(!p_latch, "R7 latch width", 2, 1);
          chk(bit_idx == DOTS, "R5 dots before latch", bit_idx, DOTS);
        end
        if (p_latch && !ph_latch)
          chk(ph_burn, "R8 burn after latch", ph_burn, 1);
        if (ph_burn) burn_cnt++;
        if (p_burn && !ph_burn) begin
          chk(burn_cnt == run_k + 1, "R8 burn length", burn_cnt, run_k + 1);
          chk(paper_adv, "R9 advance after burn", paper_adv, 1);
          burn_cnt = 0;
        end
        if (paper_adv) begin
          chk(!p_adv, "R9 advance width", 2, 1);
          row_idx++;
          bit_idx = 0;
        end
        if (done) begin
          chk(!p_done, "R10 done width", 2, 1);
          chk(p_adv, "R10 done after advance", p_adv, 1);
          chk(!busy, "R10 busy low", busy, 0);
          chk(row_idx == ROWS, "R10 row count", row_idx, ROWS);
          chk(exp_addr == ROWS * WPR, "R3 word count", exp_addr, ROWS * WPR);
          done_seen = 1'b1;
        end
      end
      p_clk = ph_clk; p_data = ph_data; p_latch = ph_latch;
      p_burn = ph_burn; p_adv = paper_adv; p_done = done;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, rd_valid, ph_clk, ph_latch, ph_burn, paper_adv} == 7'b0,
        "R1 reset outputs", {busy, done, rd_valid, ph_clk, ph_latch, ph_burn, paper_adv}, 0);
    mon_on = 1'b1;
    for (int sm = 0; sm < 3; sm++) begin
      for (int l = 0; l <= 35; l++) begin
        int guard;
        stall_mode = sm;
        lat        = l;
        run_k      = (l + sm) % 4;
        exp_addr   = 0;
        row_idx    = 0;
        bit_idx    = 0;
        done_seen  = 1'b0;
        @(negedge clk);
        strobe_len = STB_W'(run_k);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        chk(busy, "R2 busy after start", busy, 1);
        repeat (18) @(negedge clk);
        // start while busy must be ignored; new strobe value must not take effect
        strobe_len = STB_W'(run_k + 7);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        chk(busy, "R2 still busy", busy, 1);
        guard = 0;
        while (!done_seen && guard < 4000) begin
          @(negedge clk);
          guard++;
        end
        chk(done_seen, "R10 dump finished", done_seen, 1);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !rd_valid, "R2 idle after dump", busy, 0);
      end
    end
    summary();
  end
endmodule